// File: doc/BRIEF.md
# Aligned Interrupt Stack-Frame Pusher

This block builds the stack frame that interrupt entry needs. It writes the frame through a memory port that only writes. A single start request carries everything the frame needs: the current stack pointer and selector, an already chosen stack pointer for a stack switch, flags, the code selector, the return pointer, an optional error code, and the mode bits. The block picks the base stack pointer. In long mode it rounds that pointer down to a 16-byte boundary. It then writes the frame words one at a time, going down in memory.

Each write is presented on the port together with its address, its data and its byte count. The write is held on the port until the memory accepts it. After the last word is taken, the block pulses a done signal and returns the final stack pointer. While a frame is in progress, the block is busy and does not take a new request.

Top module: `frame_pusher`

## Requirements
- R1: After reset, `busy`, `memWrValid` and `doneValid` are all low.
- R2: When `longMode` is set, bits 3:0 of the base stack pointer are cleared before the first write. The first write address is therefore the aligned base minus 8.
- R3: When `longMode` is set, every write has `memBytes` = 8 and carries the full 64-bit value.
- R4: When `longMode` is set, the old selector and the old stack pointer are always written, whatever `switchStack` is. The old stack pointer written is `curSp` as given, before any alignment.
- R5: When `longMode` is clear, the old selector and the old stack pointer are written only if `switchStack` is set.
- R6: When `longMode` is clear, each write is 4 bytes if `gateWide` is 1 and 2 bytes if it is 0. The data is zero-extended above that width, and no alignment is applied.
- R7: The slots are written from the highest address down in this order: old selector, old stack pointer, flags, code selector, return pointer, and last the error code. The error code slot is present only when `hasErr` is set.
- R8: The base stack pointer is `newSp` when `switchStack` is set and `curSp` otherwise.
- R9: Each write address equals the current stack pointer minus the push width. The pointer moves down by the push width only when a write is accepted (`memWrValid` and `memReady` both high). While `memReady` is low, the address and data stay unchanged.
- R10: `doneValid` is high for exactly one cycle. That cycle is the one right after the last write is accepted. During it, `doneSp` equals the address of the last write.
- R11: A `startValid` that arrives while `busy` is high is ignored. The frame in progress is written unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request, taken when not busy |
| longMode | input | 1 | 1 = long mode: 8-byte pushes, alignment, stack always saved |
| gateWide | input | 1 | Legacy push width: 1 = 4 bytes, 0 = 2 bytes |
| switchStack | input | 1 | Privilege change: use newSp as base |
| hasErr | input | 1 | Error code slot present |
| curSp | input | SP_W | Interrupted stack pointer |
| newSp | input | SP_W | Stack pointer to switch to |
| curSs | input | SEL_W | Interrupted stack selector |
| curCs | input | SEL_W | Interrupted code selector |
| flags | input | 64 | Flags value to save |
| retIp | input | 64 | Return pointer |
| errCode | input | 64 | Error code |
| memReady | input | 1 | Memory accepts the write presented |
| memWrValid | output | 1 | Write presented |
| memAddr | output | SP_W | Byte address of the write |
| memData | output | 64 | Write data, zero-extended |
| memBytes | output | 4 | Write width in bytes (2, 4 or 8) |
| busy | output | 1 | Frame in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneSp | output | SP_W | Final stack pointer |

## Verification
Suppose the slot counter or the skip decision goes wrong. Then a word is missing, repeated or out of order, and the bench catches it in the same cycle that word reaches `memAddr`/`memData`. Suppose the stack pointer register is wrong, through a bad alignment mask, a wrong width or a step taken during a stall. Then the very first write address shows it, and every later address and the returned `doneSp` show it too. The bench sets the error-code slot both present and absent. Combined with the stalls, this makes a wrong end condition appear as a missing or extra write, or as a done pulse one cycle early or late.

// File: rtl/pusher_pkg.sv
package pusher_pkg;
  typedef enum logic [2:0] {
    SLOT_SS  = 3'd0,
    SLOT_SP  = 3'd1,
    SLOT_FL  = 3'd2,
    SLOT_CS  = 3'd3,
    SLOT_IP  = 3'd4,
    SLOT_ERR = 3'd5
  } slot_e;

  typedef struct packed {
    logic  load;
    logic  step;
    slot_e slot;
  } strobe_t;
endpackage

// File: rtl/pusher_ctrl.sv
module pusher_ctrl
  import pusher_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  logic    longMode,
  input  logic    switchStack,
  input  logic    hasErr,
  input  logic    memReady,
  output strobe_t strb,
  output logic    busy,
  output logic    memWrValid,
  output logic    doneValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE} state_e;
  state_e state;
  slot_e  slot, lastSlot;

  always_comb begin
    strb.load  = startValid && (state == ST_IDLE);
    strb.step  = (state == ST_PUSH) && memReady;
    strb.slot  = slot;
    busy       = (state != ST_IDLE);
    memWrValid = (state == ST_PUSH);
    doneValid  = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slot     <= SLOT_SS;
      lastSlot <= SLOT_IP;
    end else begin
      case (state)
        ST_IDLE: if (strb.load) begin
          state    <= ST_PUSH;
          slot     <= (longMode || switchStack) ? SLOT_SS : SLOT_FL;
          lastSlot <= hasErr ? SLOT_ERR : SLOT_IP;
        end
        ST_PUSH: if (strb.step) begin
          if (slot == lastSlot) state <= ST_DONE;
          else slot <= slot_e'(slot + 3'd1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle pulse that follows an accepted write
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneValid) |-> $past(memWrValid && memReady));
  // R7: slots only move upward through the list
  assert_slot_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && slot != lastSlot) |=> (slot > $past(slot)));
  // R11: busy only rises because a start was requested
  assert_start_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid));
endmodule

// File: rtl/pusher_dp.sv
module pusher_dp
  import pusher_pkg::*;
#(
  parameter int SP_W  = 64,
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              longMode,
  input  logic              gateWide,
  input  logic              switchStack,
  input  logic [SP_W-1:0]   curSp,
  input  logic [SP_W-1:0]   newSp,
  input  logic [SEL_W-1:0]  curSs,
  input  logic [SEL_W-1:0]  curCs,
  input  logic [63:0]       flags,
  input  logic [63:0]       retIp,
  input  logic [63:0]       errCode,
  output logic [SP_W-1:0]   memAddr,
  output logic [63:0]       memData,
  output logic [3:0]        memBytes,
  output logic [SP_W-1:0]   finalSp
);
  localparam int ALIGN_BITS = 4;
  localparam logic [SP_W-1:0] ALIGN_MASK = ~SP_W'((1 << ALIGN_BITS) - 1);

  logic [SP_W-1:0]  spReg, oldSp, baseSp;
  logic [SEL_W-1:0] ssReg, csReg;
  logic [63:0]      flReg, ipReg, errReg, rawWord, dataMask;
  logic             longReg, wideReg;
  logic [3:0]       pushBytes;

  always_comb begin
    baseSp = switchStack ? newSp : curSp;
    if (longMode) baseSp = baseSp & ALIGN_MASK;
  end

  always_comb begin
    if (longReg) begin
      pushBytes = 4'd8;  dataMask = '1;
    end else if (wideReg) begin
      pushBytes = 4'd4;  dataMask = 64'h0000_0000_FFFF_FFFF;
    end else begin
      pushBytes = 4'd2;  dataMask = 64'h0000_0000_0000_FFFF;
    end
  end

  always_comb begin
    case (strb.slot)
      SLOT_SS:  rawWord = 64'(ssReg);
      SLOT_SP:  rawWord = 64'(oldSp);
      SLOT_FL:  rawWord = flReg;
      SLOT_CS:  rawWord = 64'(csReg);
      SLOT_IP:  rawWord = ipReg;
      default:  rawWord = errReg;
    endcase
  end

  assign memAddr  = spReg - SP_W'(pushBytes);
  assign memData  = rawWord & dataMask;
  assign memBytes = pushBytes;
  assign finalSp  = spReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg <= '0;  oldSp <= '0;  ssReg <= '0;  csReg <= '0;
      flReg <= '0;  ipReg <= '0;  errReg <= '0;
      longReg <= 1'b0;  wideReg <= 1'b0;
    end else if (strb.load) begin
      spReg <= baseSp;   oldSp <= curSp;  ssReg <= curSs;  csReg <= curCs;
      flReg <= flags;    ipReg <= retIp;  errReg <= errCode;
      longReg <= longMode;  wideReg <= gateWide;
    end else if (strb.step) begin
      spReg <= memAddr;
    end
  end

  // R2: the loaded base is 16-byte aligned in long mode
  assert_aligned_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.load) && longReg) |-> (spReg[3:0] == 4'd0));
  // R9: an accepted write moves the pointer down by exactly one push width
  assert_step_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.step) |-> (spReg == $past(spReg) - SP_W'($past(pushBytes))));
  // R3: long-mode pushes are eight bytes
  assert_long_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    longReg |-> (memBytes == 4'd8));
endmodule

// File: rtl/frame_pusher.sv
module frame_pusher
  import pusher_pkg::*;
#(
  parameter int SP_W  = 64,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             longMode,
  input  logic             gateWide,
  input  logic             switchStack,
  input  logic             hasErr,
  input  logic [SP_W-1:0]  curSp,
  input  logic [SP_W-1:0]  newSp,
  input  logic [SEL_W-1:0] curSs,
  input  logic [SEL_W-1:0] curCs,
  input  logic [63:0]      flags,
  input  logic [63:0]      retIp,
  input  logic [63:0]      errCode,
  input  logic             memReady,
  output logic             memWrValid,
  output logic [SP_W-1:0]  memAddr,
  output logic [63:0]      memData,
  output logic [3:0]       memBytes,
  output logic             busy,
  output logic             doneValid,
  output logic [SP_W-1:0]  doneSp
);
  strobe_t strb;

  pusher_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .longMode(longMode),
    .switchStack(switchStack), .hasErr(hasErr), .memReady(memReady),
    .strb(strb), .busy(busy), .memWrValid(memWrValid), .doneValid(doneValid)
  );

  pusher_dp #(.SP_W(SP_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .longMode(longMode),
    .gateWide(gateWide), .switchStack(switchStack), .curSp(curSp),
    .newSp(newSp), .curSs(curSs), .curCs(curCs), .flags(flags),
    .retIp(retIp), .errCode(errCode), .memAddr(memAddr), .memData(memData),
    .memBytes(memBytes), .finalSp(doneSp)
  );

  // R9: a stalled write holds its address and data
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memReady) |=> (memWrValid && $stable(memAddr) && $stable(memData)));
endmodule

// File: tb/tb_frame_pusher.sv
module tb_frame_pusher;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 0, longMode = 0, gateWide = 0, switchStack = 0, hasErr = 0;
  logic [63:0] curSp = '0, newSp = '0, flags = '0, retIp = '0, errCode = '0;
  logic [15:0] curSs = '0, curCs = '0;
  logic memReady = 0;
  logic memWrValid, busy, doneValid;
  logic [63:0] memAddr, memData, doneSp;
  logic [3:0] memBytes;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  frame_pusher dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame: expected words computed from the requirements
  task automatic doFrame(input bit lm, input bit wide, input bit sw, input bit err,
                         input logic [63:0] cSp, input logic [63:0] nSp,
                         input logic [7:0] readyPat, input bit jam, input string tag);
    logic [63:0] vals[6];
    logic [63:0] exAddr[6], exData[6];
    logic [63:0] base, mask, sp;
    int w, n, k, idx;
    vals[0] = 64'h0000_0000_0000_002B; vals[1] = cSp;
    vals[2] = 64'h0000_0000_0024_0246; vals[3] = 64'h0000_0000_0000_0033;
    vals[4] = 64'hFFFF_8000_1234_5678; vals[5] = 64'h0000_0000_0000_0E0E;
    base = sw ? nSp : cSp;
    if (lm) base = base & ~64'hF;                              // R2, R8
    w    = lm ? 8 : (wide ? 4 : 2);                            // R3, R6
    mask = lm ? '1 : (wide ? 64'hFFFF_FFFF : 64'hFFFF);
    n = 0; sp = base;
    for (int s = 0; s < 6; s++) begin                          // R4, R5, R7
      if (s < 2 && !(lm || sw)) continue;
      if (s == 5 && !err) continue;
      sp = sp - 64'(w);
      exAddr[n] = sp; exData[n] = vals[s] & mask; n++;
    end
    @(negedge clk);
    startValid = 1; longMode = lm; gateWide = wide; switchStack = sw; hasErr = err;
    curSp = cSp; newSp = nSp; curSs = vals[0][15:0]; curCs = vals[3][15:0];
    flags = vals[2]; retIp = vals[4]; errCode = vals[5];
    @(negedge clk);
    startValid = jam;
    if (jam) begin  // R11: scrambled request while busy
      longMode = ~lm; switchStack = ~sw; hasErr = ~err; curSp = ~cSp; newSp = ~nSp;
      flags = '1; retIp = '0;
    end
    idx = 0; k = 0;
    while (idx < n && k < 200) begin
      memReady = readyPat[k % 8];
      if (idx == n - 1) startValid = 0;
      chk(memWrValid === 1'b1, {tag, " R9 write valid"}, 64'(memWrValid), 64'd1);
      chk(memAddr === exAddr[idx], {tag, " R9 R7 address"}, memAddr, exAddr[idx]);
      chk(memData === exData[idx], {tag, " R7 data"}, memData, exData[idx]);
      chk(memBytes === 4'(w), {tag, " R3 R6 width"}, 64'(memBytes), 64'(w));
      if (memReady) idx++;
      k++;
      @(negedge clk);
    end
    memReady = 0; startValid = 0;
    chk(doneValid === 1'b1, {tag, " R10 done pulse"}, 64'(doneValid), 64'd1);
    chk(doneSp === sp, {tag, " R10 final sp"}, doneSp, sp);
    chk(memWrValid === 1'b0, {tag, " R7 no extra write"}, 64'(memWrValid), 64'd0);
    @(negedge clk);
    chk(doneValid === 1'b0, {tag, " R10 pulse width"}, 64'(doneValid), 64'd0);
    chk(busy === 1'b0, {tag, " R11 idle after frame"}, 64'(busy), 64'd0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(memWrValid === 1'b0, "R1 write", 64'(memWrValid), 64'd0);
    chk(doneValid === 1'b0, "R1 done", 64'(doneValid), 64'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    testReset();
    doFrame(1, 0, 0, 1, 64'h0000_7FFF_0000_1237, 64'h0, 8'hFF, 0, "long-noswitch-err");
    doFrame(1, 1, 1, 0, 64'h0000_0000_0000_4001, 64'h0000_7FFF_0000_9ABF, 8'b1011_0010, 0, "long-switch-stall");
    doFrame(0, 1, 0, 1, 64'h0000_0000_0000_1237, 64'h0000_0000_0000_8000, 8'hFF, 0, "legacy32-noswitch");
    doFrame(0, 0, 1, 0, 64'h0000_0000_0000_0FFE, 64'h0000_0000_0000_2003, 8'b0110_1101, 1, "legacy16-switch-jam");
    doFrame(0, 1, 1, 1, 64'h0000_0000_0000_0202, 64'h0000_0000_0000_3006, 8'hFF, 0, "legacy32-switch-err");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule